// File: doc/BRIEF.md
# Buffered Period/Duty Pulse Generator

This block drives one pulse-width-modulated output from an 8-bit timer. A selectable prescaler divides the clock before it reaches the timer. The cycle length comes from a period register. The high time comes from a duty register.

A host may rewrite the duty value at any moment. The comparator never uses that register directly. It works from an active copy, and the active copy is refreshed only when the timer wraps at the period boundary, so a running pulse is never cut short or stretched by a write.

A sleep input stops the block where it is. The timer, the prescaler and every register hold their values, writes are refused, and the output keeps its level. When sleep drops, counting carries on from the same point. A phase-shift byte is also kept for a slave-phase arrangement; the block only stores it and returns it on reads.

Top module: `pwm_buffered`

## Requirements
- R1: After reset the output is low and every readable address returns 0.
- R2: Register addresses are 0 control, 1 period, 2 duty, 3 phase byte and 4 active duty (read-only). Control bit 2 is timer-on and bits 1:0 are prescale select. Control bits 7:3 read as 0. Period, duty and phase read back as written. Other addresses read 0.
- R3: The prescale select picks the divide ratio: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. With period P and ratio N, one output cycle lasts (P+1)·N clocks.
- R4: With active duty D not above P, the output is high for D·N clocks of each cycle and low for the rest.
- R5: A duty write reaches the active duty, and so the output, only at the next timer/period match. The pulse in progress keeps its old width.
- R6: An active duty of 0 keeps the output low for the whole cycle. An active duty above the period keeps it high for the whole cycle.
- R7: While sleep is high the output holds its level and the timer and prescaler do not move. Each sleeping clock adds exactly one clock to the cycle in progress.
- R8: Register writes made while sleep is high are ignored.
- R9: While timer-on is 0 the output is driven low and the timer and prescaler stay at 0.
- R10: The output rises only at a period boundary, when the timer restarts at 0 with a nonzero active duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Freeze request |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data, combinational |
| pwmOut | output | 1 | Pulse output |

## Verification
The bench goes after a duty write that lands in the middle of a high phase. A design without the shadow copy would truncate that pulse, and the bench would show it through a short high count and an early change in the active duty readback. Sleep is applied inside a high phase. A design that kept counting, or that let the output fall, would produce a high phase shorter than duty plus the sleep length. The bench also checks duty 0, duty above the period, and all four prescale codes, where a wrong divide table shows up as a cycle of the wrong length. A write made during sleep must leave the period register unchanged.

// File: rtl/pwm_buffered_pkg.sv
package pwm_buffered_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DUTY   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PHASE  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ACTIVE = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic run;   // timer enabled
    logic hold;  // frozen by sleep
    logic tick;  // prescaled count enable
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_buffered_ctrl.sv
module pwm_buffered_ctrl
  import pwm_buffered_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PS_STEP  = 2,
  parameter int PS_CODES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sleep,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  output logic                        timerOn,
  output logic [$clog2(PS_CODES)-1:0] psSel,
  output logic [DATA_W-1:0]           periodReg,
  output logic [DATA_W-1:0]           dutyReg,
  output logic [DATA_W-1:0]           phaseReg,
  output pwmStrobe_t                  strobe
);
  localparam int SEL_W = $clog2(PS_CODES);
  localparam int PRE_W = PS_STEP * (PS_CODES - 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic [PRE_W-1:0] limTab [PS_CODES];
  logic             preWrap;

  // divide ratios 1, 4, 16, 64 for the default parameters
  for (genvar g = 0; g < PS_CODES; g++) begin : g_lim
    assign limTab[g] = PRE_W'((64'd1 << (PS_STEP * g)) - 64'd1);
  end

  assign preLim  = limTab[psSel];
  assign preWrap = (preCnt == preLim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerOn   <= 1'b0;
      psSel     <= '0;
      periodReg <= '0;
      dutyReg   <= '0;
      phaseReg  <= '0;
    end else if (wrEn && !sleep) begin
      unique case (wrAddr)
        ADR_CTRL:   begin
                      psSel   <= wrData[SEL_W-1:0];
                      timerOn <= wrData[SEL_W];
                    end
        ADR_PERIOD: periodReg <= wrData;
        ADR_DUTY:   dutyReg   <= wrData;
        ADR_PHASE:  phaseReg  <= wrData;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         preCnt <= '0;
    else if (sleep)    preCnt <= preCnt;
    else if (!timerOn) preCnt <= '0;
    else if (preWrap)  preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobe.run  = timerOn;
    strobe.hold = sleep;
    strobe.tick = timerOn && !sleep && preWrap;
  end
endmodule

// File: rtl/pwm_buffered_dp.sv
module pwm_buffered_dp
  import pwm_buffered_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic [DATA_W-1:0] periodReg,
  input  logic [DATA_W-1:0] dutyReg,
  output logic [DATA_W-1:0] timerVal,
  output logic [DATA_W-1:0] activeDuty,
  output logic              pwmOut
);
  logic [DATA_W-1:0] timerNext;
  logic              periodHit;

  assign timerNext = timerVal + 1'b1;
  assign periodHit = (timerVal == periodReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerVal   <= '0;
      activeDuty <= '0;
      pwmOut     <= 1'b0;
    end else if (strobe.hold) begin
      timerVal   <= timerVal;
      activeDuty <= activeDuty;
      pwmOut     <= pwmOut;
    end else if (!strobe.run) begin
      timerVal <= '0;
      pwmOut   <= 1'b0;
    end else if (strobe.tick) begin
      if (periodHit) begin
        timerVal   <= '0;
        activeDuty <= dutyReg;
        pwmOut     <= (dutyReg != '0);
      end else begin
        timerVal <= timerNext;
        if (timerNext == activeDuty) pwmOut <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_buffered.sv
module pwm_buffered
  import pwm_buffered_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PS_STEP  = 2,
  parameter int PS_CODES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut
);
  localparam int SEL_W = $clog2(PS_CODES);

  pwmStrobe_t        strobe;
  logic              timerOn;
  logic [SEL_W-1:0]  psSel;
  logic [DATA_W-1:0] periodReg, dutyReg, phaseReg;
  logic [DATA_W-1:0] timerVal, activeDuty;

  pwm_buffered_ctrl #(.DATA_W(DATA_W), .PS_STEP(PS_STEP), .PS_CODES(PS_CODES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleep(sleep), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .timerOn(timerOn), .psSel(psSel), .periodReg(periodReg),
    .dutyReg(dutyReg), .phaseReg(phaseReg), .strobe(strobe)
  );

  pwm_buffered_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodReg(periodReg),
    .dutyReg(dutyReg), .timerVal(timerVal), .activeDuty(activeDuty),
    .pwmOut(pwmOut)
  );

  always_comb begin
    unique case (rdAddr)
      ADR_CTRL:   rdData = DATA_W'({timerOn, psSel});
      ADR_PERIOD: rdData = periodReg;
      ADR_DUTY:   rdData = dutyReg;
      ADR_PHASE:  rdData = phaseReg;
      ADR_ACTIVE: rdData = activeDuty;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwm_buffered_chk.sv
module pwm_buffered_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleep,
  input logic              pwmOut,
  input logic              timerOn,
  input logic [DATA_W-1:0] timerVal,
  input logic [DATA_W-1:0] activeDuty,
  input logic [2:0]        rdAddr,
  input logic [DATA_W-1:0] rdData
);
  assert_sleep_hold_out_R7: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(pwmOut));

  assert_sleep_hold_timer_R7: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(timerVal));

  assert_off_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!timerOn && !sleep) |=> (!pwmOut && timerVal == '0));

  assert_rise_at_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (timerVal == '0 && activeDuty != '0));

  assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 3'd0) |-> (rdData[DATA_W-1:3] == '0));
endmodule

bind pwm_buffered pwm_buffered_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .pwmOut(pwmOut), .timerOn(timerOn),
  .timerVal(timerVal), .activeDuty(activeDuty), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/pwm_buffered_tb.sv
`timescale 1ns/1ps
module pwm_buffered_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleep = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       pwmOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_buffered u_dut (
    .clk(clk), .rstN(rstN), .sleep(sleep), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output int v);
    @(negedge clk);
    rdAddr = a;
    #1 v = int'(rdData);
  endtask

  task automatic setup(input int p, input int d, input int ps);
    regWrite(3'd0, 8'h00);
    regWrite(3'd1, 8'(p));
    regWrite(3'd2, 8'(d));
    regWrite(3'd0, 8'(4 + ps));
  endtask

  // measure one cycle from a rising edge to the next; optional duty write
  // right after the rise, optional sleep burst inside the high phase
  task automatic measure(output int hi, output int tot, input int wrDuty,
                         input int sleepLen, input int oldDuty);
    int  guard = 0;
    int  sleepLeft = 0;
    bit  sawLow = 0;
    while (pwmOut !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    while (pwmOut !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    hi = 1; tot = 1;
    rdAddr = 3'd4;
    while (guard < 20000) begin
      if (tot == 1 && wrDuty >= 0) begin
        wrEn = 1'b1; wrAddr = 3'd2; wrData = 8'(wrDuty);
      end
      if (tot == 2 && sleepLen > 0) begin
        sleep = 1'b1; sleepLeft = sleepLen;
      end
      @(negedge clk);
      guard++;
      if (wrEn) begin
        wrEn = 1'b0;
        #1 chk(int'(rdData) == oldDuty, "R5 active duty unchanged mid-cycle", int'(rdData), oldDuty);
      end
      if (sleepLeft > 0) begin
        sleepLeft--;
        if (sleepLeft == 0) sleep = 1'b0;
      end
      if (pwmOut && sawLow) break;
      if (pwmOut) hi++; else sawLow = 1;
      tot++;
    end
  endtask

  task automatic testReset();
    int v;
    chk(pwmOut == 1'b0, "R1 output low after reset", int'(pwmOut), 0);
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), v);
      chk(v == 0, "R1 readback zero after reset", v, 0);
    end
  endtask

  task automatic testRegs();
    int v;
    regWrite(3'd0, 8'hFB);
    regRead(3'd0, v);
    chk(v == 8'h03, "R2 control upper bits read 0", v, 3);
    regWrite(3'd3, 8'hA5);
    regRead(3'd3, v);
    chk(v == 8'hA5, "R2 phase byte readback", v, 8'hA5);
    regRead(3'd6, v);
    chk(v == 0, "R2 unused address reads 0", v, 0);
    regWrite(3'd0, 8'h00);
  endtask

  task automatic testPrescale(input int ps, input int p, input int d);
    int hi, tot, n;
    n = 1 << (2 * ps);
    setup(p, d, ps);
    measure(hi, tot, -1, 0, d);
    chk(tot == (p + 1) * n, "R3 cycle length", tot, (p + 1) * n);
    chk(hi == d * n, "R4 high time", hi, d * n);
  endtask

  task automatic testShadow();
    int hi, tot;
    setup(9, 5, 0);
    measure(hi, tot, 2, 0, 5);
    chk(hi == 5, "R5 pulse in progress keeps old width", hi, 5);
    measure(hi, tot, -1, 0, 2);
    chk(hi == 2, "R5 new duty after boundary", hi, 2);
    chk(tot == 10, "R5 cycle length unchanged", tot, 10);
  endtask

  task automatic testSleep();
    int hi, tot, v;
    setup(9, 5, 0);
    measure(hi, tot, -1, 7, 5);
    chk(hi == 12, "R7 high phase stretched by sleep", hi, 12);
    chk(tot == 17, "R7 cycle stretched by sleep", tot, 17);
    @(negedge clk);
    sleep = 1'b1;
    regWrite(3'd1, 8'h33);
    @(negedge clk);
    sleep = 1'b0;
    regRead(3'd1, v);
    chk(v == 9, "R8 period write ignored in sleep", v, 9);
  endtask

  task automatic testExtremes();
    int highs;
    setup(9, 0, 0);
    repeat (25) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); highs += int'(pwmOut); end
    chk(highs == 0, "R6 duty zero stays low", highs, 0);
    setup(9, 20, 0);
    repeat (25) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); highs += int'(pwmOut); end
    chk(highs == 30, "R6 duty above period stays high", highs, 30);
  endtask

  task automatic testOff();
    int highs;
    regWrite(3'd0, 8'h00);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); highs += int'(pwmOut); end
    chk(highs == 0, "R9 output low while timer off", highs, 0);
  endtask

  initial begin
    #300000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testPrescale(0, 9, 3);
    testPrescale(1, 9, 3);
    testPrescale(2, 3, 1);
    testPrescale(3, 3, 1);
    testShadow();
    testSleep();
    testExtremes();
    testOff();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule